// File: doc/BRIEF.md
# Split-width timer and PWM channel

This block is one channel of a timer/PWM peripheral. It owns a single counting resource made of four byte-wide lanes, and a mode field decides at run time how those lanes are grouped. The lanes can act as one wide timer, two half-width timers or four byte timers. They can also be grouped as a PWM generator, or as a mix of timers and a PWM generator. A larger peripheral can place several identical copies of this channel side by side.

Every timer counts down from its slice of a shared reload word. When a count of zero meets a tick, the timer reloads and raises a sticky status bit. The PWM generator alternates between a high phase and a low phase, and the length of each phase comes from its own reload field. Counters advance either on every bus clock or once per rising edge of an external tick that is first synchronized. Software drives the channel with simple write cycles on the bus clock.

Top module: `splitpit_channel`

## Requirements
- R1: After reset, irq_status is 0, irq is 0 and pwm_out is 0. All units are disabled, mode is 0 and the tick source is the bus clock.
- R2: Mode 0 forms one 32-bit timer (unit 0) from reload bits [31:0]. A timer with reload N sets its status bit once every N+1 ticks: it counts N down to 0, and the tick that finds 0 reloads it and sets the bit.
- R3: Mode 1 forms two independent 16-bit timers. Unit 0 uses reload [15:0] and unit 1 uses reload [31:16], each with its own status bit.
- R4: Mode 2 forms four independent 8-bit timers. Unit k uses reload bits [8k+7:8k] and status bit k.
- R5: Mode 3 forms one 16-bit PWM with high count H = reload [31:16] and low count L = reload [15:0]. After a restart, pwm_out is high for H+1 ticks and then low for L+1 ticks, and the pattern repeats.
- R6: Mode 4 forms a 16-bit timer (unit 0, reload [15:0]) and an 8-bit PWM. Mode 5 forms two 8-bit timers (unit 0 with reload [7:0], unit 1 with reload [15:8]) and an 8-bit PWM. In both modes the PWM takes its low count from reload [23:16] and its high count from reload [31:24].
- R7: When the PWM is disabled, or the mode has no PWM, pwm_out equals the park bit (control bit 4).
- R8: Status bits are sticky and are cleared by writing 1 to them at address 4. A set in the same cycle as a clear wins. irq is the OR of the status bits that are masked by the interrupt-enable bits (address 3, bits [3:0]).
- R9: With control bit 3 set, the counters advance once per rising edge of ext_tick, seen through a two-flop synchronizer. A long high level on ext_tick gives only one advance.
- R10: A write to the control register (address 0, mode in bits [2:0]) or the enable register (address 1: timer enables in bits [3:0], PWM enable in bit 4) restarts every active unit on the next tick. Timers reload, and the PWM reloads its high count and drives its high phase. Until that tick, pwm_out shows the park level. A write to the reload word only (address 2) takes effect at the next expiry.
- R11: An enable bit for a unit that the current mode lacks has no effect. Mode codes 6 and 7 run no unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External tick, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 4*LANE_W | Write data |
| irq_status | output | 4 | Sticky expiry flags of timer units 0 to 3 |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest situation to reach is a reconfiguration while lanes still hold counts from the old grouping. One example is switching from four byte timers to a 16-bit PWM while a borrow would cross a lane boundary. Another is a write that lands in the same cycle as an expiry or a W1C clear. The random phase writes the mode, enable and status registers at random moments, using small reload bytes so that expiries stay frequent. This makes such collisions common, and a bench model compares every output on every cycle.

// File: rtl/splitpit_pkg.sv
package splitpit_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned TIMERS = 4;
   localparam int unsigned UNITS  = TIMERS + 1;

   localparam logic [2:0] UNIT_PWM  = 3'd4;
   localparam logic [2:0] UNIT_NONE = 3'd7;

   localparam logic [2:0] MODE_T32     = 3'd0;
   localparam logic [2:0] MODE_T16X2   = 3'd1;
   localparam logic [2:0] MODE_T8X4    = 3'd2;
   localparam logic [2:0] MODE_P16     = 3'd3;
   localparam logic [2:0] MODE_T16_P8  = 3'd4;
   localparam logic [2:0] MODE_T8X2_P8 = 3'd5;

   localparam int unsigned A_CTRL   = 0;
   localparam int unsigned A_ENA    = 1;
   localparam int unsigned A_RELOAD = 2;
   localparam int unsigned A_IEN    = 3;
   localparam int unsigned A_STAT   = 4;

   // Which unit a byte lane belongs to in a given mode
   function automatic logic [2:0] lane_unit(input logic [2:0] mode, input int unsigned lane);
      logic [2:0] l;
      l = 3'(lane);
      case (mode)
         MODE_T32:     return 3'd0;
         MODE_T16X2:   return (l < 3'd2) ? 3'd0 : 3'd1;
         MODE_T8X4:    return l;
         MODE_P16:     return (l < 3'd2) ? UNIT_PWM : UNIT_NONE;
         MODE_T16_P8:  return (l < 3'd2) ? 3'd0 : ((l == 3'd2) ? UNIT_PWM : UNIT_NONE);
         MODE_T8X2_P8: return (l == 3'd0) ? 3'd0 : (l == 3'd1) ? 3'd1 :
                              ((l == 3'd2) ? UNIT_PWM : UNIT_NONE);
         default:      return UNIT_NONE;
      endcase
   endfunction
endpackage

// File: rtl/splitpit_ticksel.sv
module splitpit_ticksel #(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ext_tick,
   input  logic ext_sel,
   output logic ext_pulse,
   output logic tick
);
   // SYNC_STAGES flops of synchronizer plus one for edge detection
   logic [SYNC_STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_tick};
   end

   assign ext_pulse = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
   assign tick      = ext_sel ? ext_pulse : 1'b1;
endmodule

// File: rtl/splitpit_regs.sv
module splitpit_regs import splitpit_pkg::*; #(
   parameter  int unsigned LANE_W = 8,
   parameter  int unsigned ADDR_W = 3,
   localparam int unsigned RL_W   = LANES * LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [RL_W-1:0]   wr_data,
   input  logic              tick,
   input  logic [TIMERS-1:0] sts_set,
   output logic [2:0]        mode,
   output logic              ext_sel,
   output logic              park,
   output logic [UNITS-1:0]  unit_en,
   output logic [RL_W-1:0]   reload,
   output logic [TIMERS-1:0] ien,
   output logic [TIMERS-1:0] sts,
   output logic              restart,
   output logic              cfg_wr
);
   logic              hit_ctrl, hit_ena, hit_rel, hit_ien, hit_stat;
   logic [TIMERS-1:0] clr;

   assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign hit_ena  = wr_en && (wr_addr == ADDR_W'(A_ENA));
   assign hit_rel  = wr_en && (wr_addr == ADDR_W'(A_RELOAD));
   assign hit_ien  = wr_en && (wr_addr == ADDR_W'(A_IEN));
   assign hit_stat = wr_en && (wr_addr == ADDR_W'(A_STAT));
   assign cfg_wr   = hit_ctrl | hit_ena;
   assign clr      = hit_stat ? wr_data[TIMERS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MODE_T32;
         ext_sel <= 1'b0;
         park    <= 1'b0;
         unit_en <= '0;
         reload  <= '0;
         ien     <= '0;
         sts     <= '0;
         restart <= 1'b0;
      end else begin
         if (hit_ctrl) {park, ext_sel, mode} <= wr_data[4:0];
         if (hit_ena)  unit_en <= wr_data[UNITS-1:0];
         if (hit_rel)  reload  <= wr_data;
         if (hit_ien)  ien     <= wr_data[TIMERS-1:0];
         sts <= (sts & ~clr) | sts_set;
         if (cfg_wr)    restart <= 1'b1;
         else if (tick) restart <= 1'b0;
      end
   end
endmodule

// File: rtl/splitpit_lanes.sv
module splitpit_lanes import splitpit_pkg::*; #(
   parameter  int unsigned LANE_W = 8,
   localparam int unsigned RL_W   = LANES * LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              restart,
   input  logic [2:0]        mode,
   input  logic [UNITS-1:0]  unit_en,
   input  logic [RL_W-1:0]   reload,
   output logic [TIMERS-1:0] sts_set,
   output logic              phase,
   output logic              pwm_live
);
   logic [2:0]       lane_u [LANES];
   logic [LANES-1:0] lane_zero, lane_act, borrow;
   logic [7:0]       unit_zero, en_x;
   logic [UNITS-1:0] unit_live;
   logic             phase_q, next_phase;

   assign en_x       = 8'(unit_en);
   assign next_phase = restart | ~phase_q;

   // Per-unit zero detect and liveness gathered across the lanes
   always_comb begin
      unit_zero = '1;
      unit_live = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!lane_zero[i]) unit_zero[lane_u[i]] = 1'b0;
         if (lane_u[i] != UNIT_NONE) unit_live[lane_u[i]] = en_x[lane_u[i]];
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cnt_q, lo_val, hi_val, ld_val;

      assign lane_u[g]    = lane_unit(mode, g);
      assign lane_zero[g] = (cnt_q == '0);
      assign lane_act[g]  = en_x[lane_u[g]];
      assign lo_val       = reload[g*LANE_W +: LANE_W];

      // High-phase byte sits one group width above the low-phase byte
      if (g + 2 < LANES) begin : g_hi2
         assign hi_val = (mode == MODE_P16) ? reload[(g+2)*LANE_W +: LANE_W]
                                            : reload[(g+1)*LANE_W +: LANE_W];
      end else if (g + 1 < LANES) begin : g_hi1
         assign hi_val = reload[(g+1)*LANE_W +: LANE_W];
      end else begin : g_hi0
         assign hi_val = lo_val;
      end

      assign ld_val = (lane_u[g] == UNIT_PWM && next_phase) ? hi_val : lo_val;

      // Borrow ripples up from the lowest lane of the group
      if (g == 0) begin : g_b0
         assign borrow[g] = 1'b1;
      end else begin : g_bn
         assign borrow[g] = (lane_u[g] != lane_u[g-1]) | (borrow[g-1] & lane_zero[g-1]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (tick && lane_act[g]) begin
            if (restart || unit_zero[lane_u[g]]) cnt_q <= ld_val;
            else if (borrow[g])                 cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   for (genvar u = 0; u < TIMERS; u++) begin : g_flag
      assign sts_set[u] = tick & unit_live[u] & ~restart & unit_zero[u];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
      end else if (tick && unit_live[UNIT_PWM]) begin
         if (restart)                  phase_q <= 1'b1;
         else if (unit_zero[UNIT_PWM]) phase_q <= ~phase_q;
      end
   end

   assign phase    = phase_q;
   assign pwm_live = unit_live[UNIT_PWM];
endmodule

// File: rtl/splitpit_channel.sv
module splitpit_channel import splitpit_pkg::*; #(
   parameter int unsigned LANE_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ext_tick,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   output logic [TIMERS-1:0]         irq_status,
   output logic                      irq,
   output logic                      pwm_out
);
   localparam int unsigned RL_W = LANES * LANE_W;

   if (LANE_W < 4)      begin : g_chk_w $error("LANE_W must be at least 4"); end
   if (ADDR_W < 3)      begin : g_chk_a $error("ADDR_W must be at least 3"); end
   if (SYNC_STAGES < 2) begin : g_chk_s $error("SYNC_STAGES must be at least 2"); end

   logic              tick, ext_pulse, ext_sel, park, restart, cfg_wr, phase, pwm_live;
   logic [2:0]        mode;
   logic [UNITS-1:0]  unit_en;
   logic [RL_W-1:0]   reload;
   logic [TIMERS-1:0] ien, sts, sts_set;

   splitpit_ticksel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .ext_sel(ext_sel),
      .ext_pulse(ext_pulse), .tick(tick));

   splitpit_regs #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tick(tick), .sts_set(sts_set), .mode(mode), .ext_sel(ext_sel), .park(park),
      .unit_en(unit_en), .reload(reload), .ien(ien), .sts(sts), .restart(restart),
      .cfg_wr(cfg_wr));

   splitpit_lanes #(.LANE_W(LANE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .mode(mode),
      .unit_en(unit_en), .reload(reload), .sts_set(sts_set), .phase(phase),
      .pwm_live(pwm_live));

   assign irq_status = sts;
   assign irq        = |(sts & ien);
   assign pwm_out    = (pwm_live && !restart) ? phase : park;
endmodule

// File: rtl/splitpit_checker.sv
module splitpit_checker #(
   parameter int unsigned ADDR_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [4:0]        wr_low,
   input logic [3:0]        irq_status,
   input logic              irq,
   input logic              pwm_out,
   input logic              tick,
   input logic              ext_pulse,
   input logic              restart,
   input logic              pwm_live
);
   logic [3:0] w1c;
   logic       cfg, park_seen;

   assign w1c = (wr_en && wr_addr == ADDR_W'(4)) ? wr_low[3:0] : 4'h0;
   assign cfg = wr_en && (wr_addr == ADDR_W'(0) || wr_addr == ADDR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) park_seen <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(0)) park_seen <= wr_low[4];
   end

   // R8: a set status bit only falls after a W1C write to it
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(irq_status) & ~$past(w1c)) & ~irq_status) == 4'h0));

   // R8: no status, no interrupt
   assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status == 4'h0) |-> !irq);

   // R7: an idle PWM shows the last written park level
   assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_live |-> (pwm_out == park_seen));

   // R9: the synchronized edge pulse lasts one cycle
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_pulse |=> !ext_pulse);

   // R10: a configuration write arms a restart
   assert_restart_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg |=> restart);

   // R5: the PWM output moves only after a tick or a configuration write
   assert_pwm_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwm_out) |-> ($past(tick) || $past(cfg)));
endmodule

bind splitpit_channel splitpit_checker #(.ADDR_W(ADDR_W)) u_splitpit_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_low(wr_data[4:0]),
   .irq_status(irq_status), .irq(irq), .pwm_out(pwm_out), .tick(tick),
   .ext_pulse(ext_pulse), .restart(restart), .pwm_live(pwm_live));

// File: tb/test_splitpit_channel.sv
module test_splitpit_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  irq_status;
   logic        irq, pwm_out;

   splitpit_channel i_splitpit_channel (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_status(irq_status), .irq(irq), .pwm_out(pwm_out));

   always #10 clk = ~clk;   // 50 MHz

   int    n_vec = 0, n_bad = 0;
   bit    done = 1'b0;
   string sec_tag = "";

   // ---------------- reference model ----------------
   logic [2:0]  m_mode;  logic m_sel, m_park, m_pend, m_ph;
   logic [4:0]  m_en;    logic [31:0] m_rl;  logic [3:0] m_ien, m_sts;
   logic [2:0]  m_s;
   longint      m_cnt [5];

   function automatic int twidth(input logic [2:0] md, input int u);
      case (md)
         3'd0: return (u == 0) ? 32 : 0;
         3'd1: return (u < 2) ? 16 : 0;
         3'd2: return 8;
         3'd4: return (u == 0) ? 16 : 0;
         3'd5: return (u < 2) ? 8 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic longint trel(input logic [2:0] md, input int u, input logic [31:0] rl);
      case (md)
         3'd0:         return longint'(rl);
         3'd1:         return (u == 0) ? longint'(rl[15:0]) : longint'(rl[31:16]);
         3'd4:         return longint'(rl[15:0]);
         default:      return longint'((rl >> (8*u)) & 32'hFF);
      endcase
   endfunction

   function automatic bit has_pwm(input logic [2:0] md);
      return (md == 3'd3 || md == 3'd4 || md == 3'd5);
   endfunction
   function automatic longint phi(input logic [2:0] md, input logic [31:0] rl);
      return (md == 3'd3) ? longint'(rl[31:16]) : longint'(rl[31:24]);
   endfunction
   function automatic longint plo(input logic [2:0] md, input logic [31:0] rl);
      return (md == 3'd3) ? longint'(rl[15:0]) : longint'(rl[23:16]);
   endfunction

   function automatic bit exp_pwm();
      return (m_en[4] && has_pwm(m_mode) && !m_pend) ? m_ph : m_park;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_sel = 0; m_park = 0; m_pend = 0; m_ph = 0;
         m_en = 0; m_rl = 0; m_ien = 0; m_sts = 0; m_s = 0;
         for (int u = 0; u < 5; u++) m_cnt[u] = 0;
      end else begin
         bit         tk;
         logic [3:0] set, clr;
         tk  = m_sel ? (m_s[1] & ~m_s[2]) : 1'b1;
         set = 0;
         for (int u = 0; u < 4; u++) begin
            if (tk && m_en[u] && twidth(m_mode, u) != 0) begin
               if (m_pend)             m_cnt[u] = trel(m_mode, u, m_rl);
               else if (m_cnt[u] == 0) begin m_cnt[u] = trel(m_mode, u, m_rl); set[u] = 1; end
               else                    m_cnt[u] = m_cnt[u] - 1;
            end
         end
         if (tk && m_en[4] && has_pwm(m_mode)) begin
            if (m_pend) begin m_ph = 1; m_cnt[4] = phi(m_mode, m_rl); end
            else if (m_cnt[4] == 0) begin
               m_ph = ~m_ph;
               m_cnt[4] = m_ph ? phi(m_mode, m_rl) : plo(m_mode, m_rl);
            end else m_cnt[4] = m_cnt[4] - 1;
         end
         clr   = (wr_en && wr_addr == 3'd4) ? wr_data[3:0] : 4'h0;
         m_sts = (m_sts & ~clr) | set;
         m_s   = {m_s[1:0], ext_tick};
         if (tk) m_pend = 0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_mode = wr_data[2:0]; m_sel = wr_data[3]; m_park = wr_data[4]; m_pend = 1; end
               3'd1: begin m_en = wr_data[4:0]; m_pend = 1; end
               3'd2: m_rl = wr_data;
               3'd3: m_ien = wr_data[3:0];
               default: ;
            endcase
         end
      end
   end

   // ---------------- checking ----------------
   function automatic string stag(input logic [2:0] md);
      case (md)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd4, 3'd5: return "R6";
         default: return "R11";
      endcase
   endfunction

   function automatic string ptag();
      if (!(m_en[4] && has_pwm(m_mode))) return "R7";
      return (m_mode == 3'd3) ? "R5" : "R6";
   endfunction

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s%s %s actual=%0h expected=%0h t=%0t", sec_tag, tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check({"R8/", stag(m_mode)}, "irq_status", longint'(irq_status), longint'(m_sts));
         check("R8", "irq", longint'(irq), longint'(|(m_sts & m_ien)));
         check(ptag(), "pwm_out", longint'(pwm_out), longint'(exp_pwm()));
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] small_rl();
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'($urandom % 6);
      return r;
   endfunction

   bit rand_ext = 1'b0;
   always @(negedge clk) if (rand_ext && ($urandom % 3 == 0)) ext_tick <= ~ext_tick;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      sec_tag = "R1 ";                        // reset state
      idle(4); rst_n = 1'b1; idle(4);

      sec_tag = "R2 ";                        // 32-bit timer, period 6
      wr(3'd2, 32'd5); wr(3'd3, 32'hF); wr(3'd0, 32'h0); wr(3'd1, 32'h1); idle(30);
      wr(3'd4, 32'hF); idle(3);
      wr(3'd2, 32'h0001_0002); wr(3'd1, 32'h1); idle(40);

      sec_tag = "R3 ";
      wr(3'd0, 32'h1); wr(3'd2, {16'd3, 16'd6}); wr(3'd1, 32'h3); idle(40); wr(3'd4, 32'hF);

      sec_tag = "R4 ";
      wr(3'd0, 32'h2); wr(3'd2, 32'h04_03_02_01); wr(3'd1, 32'hF); idle(40); wr(3'd4, 32'hF);

      sec_tag = "R5 ";
      wr(3'd0, 32'h13); wr(3'd2, {16'd2, 16'd4}); idle(3); wr(3'd1, 32'h10); idle(30);

      sec_tag = "R6 ";
      wr(3'd0, 32'h4); wr(3'd2, 32'h01_02_0003); wr(3'd1, 32'h11); idle(30);
      wr(3'd0, 32'h5); wr(3'd2, 32'h02_01_03_02); wr(3'd1, 32'h13); idle(30);

      sec_tag = "R7 ";
      wr(3'd0, 32'h15); wr(3'd1, 32'h03); idle(6);
      wr(3'd0, 32'h02); wr(3'd1, 32'h10); idle(6);

      sec_tag = "R8 ";
      wr(3'd0, 32'h2); wr(3'd2, 32'h00_01_02_00); wr(3'd3, 32'h5); wr(3'd1, 32'hF); idle(12);
      wr(3'd4, 32'h1); wr(3'd4, 32'hA); wr(3'd3, 32'h2); idle(8); wr(3'd4, 32'hF); idle(2);

      sec_tag = "R9 ";
      wr(3'd1, 32'h0); wr(3'd4, 32'hF);
      wr(3'd0, 32'h8); wr(3'd2, 32'd1); wr(3'd1, 32'h1);
      for (int k = 0; k < 6; k++) begin ext_tick = 1'b1; idle(25); ext_tick = 1'b0; idle(5); end

      sec_tag = "R10 ";
      wr(3'd0, 32'h0); wr(3'd2, 32'd9); wr(3'd1, 32'h1); idle(4);
      wr(3'd2, 32'd2); idle(20); wr(3'd1, 32'h1); idle(1); wr(3'd1, 32'h1); idle(10);

      sec_tag = "R11 ";
      wr(3'd4, 32'hF); wr(3'd0, 32'h0); wr(3'd2, 32'd1); wr(3'd1, 32'h1E); idle(12);
      wr(3'd0, 32'h6); wr(3'd1, 32'h1F); idle(10); wr(3'd0, 32'h7); idle(10);

      sec_tag = "";                           // constrained random
      rand_ext = 1'b1;
      for (int it = 0; it < 3000; it++) begin
         int sel;
         sel = $urandom % 10;
         if (sel < 5)       idle(1 + $urandom % 8);
         else if (sel == 5) wr(3'd0, {27'd0, 1'($urandom), 1'($urandom % 4 == 0), 3'($urandom)});
         else if (sel == 6) wr(3'd1, 32'($urandom % 32));
         else if (sel == 7) wr(3'd2, small_rl());
         else if (sel == 8) wr(3'd3, 32'($urandom % 16));
         else               wr(3'd4, 32'($urandom % 16));
      end
      rand_ext = 1'b0;
      idle(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule